// File: doc/BRIEF.md
# ADC Conversion Auto-Sequencer

This block drives an external analog-to-digital converter through a programmable list of conversion slots, so that no processor action is needed after a start. Each slot holds a 4-bit channel number. When a sequence runs, the block requests one conversion per slot through a start/done handshake and stores each 12-bit result in the result register whose index is the slot number, not the channel number.

The sixteen slots are used in one of two ways. In dual mode they form two independent sequencers: sequencer 1 owns slots 0 to 7 and sequencer 2 owns slots 8 to 15. In cascaded mode sequencer 1 owns all sixteen slots. Each sequencer has a run-length field, a mask that picks its start sources (a software strobe, either of two PWM events, or an external pin), a busy flag and an end-of-sequence pulse. A start that arrives while a sequencer is busy is held and runs as soon as the current sequence ends. Both sequencers share one converter. When both are waiting, sequencer 1 is served first.

Top module: `adc_autoseq`

## Requirements
- R1: After reset, conv_start, busy1, busy2, eos1 and eos2 are low and no conversion is requested until a start is latched.
- R2: A sequencer starts only on a source enabled in its 4-bit mask: bit 0 its software strobe, bit 1 PWM event A, bit 2 PWM event B, bit 3 the external pin. A pulse on a source that is not enabled has no effect.
- R3: In dual mode (cascade low), sequencer 1 converts slots 0 to max_conv1[2:0] and sequencer 2 converts slots 8 to 8+max_conv2, in rising slot order. Each request drives conv_chan with the slot's entry slot_chan[4*s+3:4*s].
- R4: In cascaded mode (cascade high), sequencer 1 converts slots 0 to max_conv1 (up to 16 slots). Starts aimed at sequencer 2 are ignored, and busy2 and eos2 stay low.
- R5: Each slot issues exactly one single-cycle conv_start. The next request is issued only after conv_done has been seen for the current one, and conv_start is only high while a sequencer is busy.
- R6: The conv_data value that comes with each conv_done is written into result register s, where s is the slot being converted. Register rd_addr appears on rd_data one clock later. Slots not converted keep their earlier values.
- R7: After the conv_done of a sequence's last slot, that sequencer's end-of-sequence output pulses for one cycle. Its busy flag is already low in that cycle.
- R8: A start that arrives while its sequencer is busy is held, and a new run of that sequencer follows the end of the current one with no further start.
- R9: When both sequencers are waiting to start, sequencer 1 runs first and sequencer 2 runs after it ends.
- R10: At most one sequencer is busy at any time, and eos1 and eos2 are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cascade | input | 1 | 1: one 16-slot sequencer; 0: two 8-slot sequencers |
| slot_chan | input | 64 | Channel number of slot s in bits 4*s+3:4*s |
| max_conv1 | input | 4 | Last slot offset of sequencer 1 (low 3 bits in dual mode) |
| max_conv2 | input | 3 | Last slot offset of sequencer 2 |
| trig_mask1 | input | 4 | Start source enables of sequencer 1 |
| trig_mask2 | input | 4 | Start source enables of sequencer 2 |
| sw_start1 | input | 1 | Software start strobe, sequencer 1 |
| sw_start2 | input | 1 | Software start strobe, sequencer 2 |
| pwm_trig_a | input | 1 | PWM event A start |
| pwm_trig_b | input | 1 | PWM event B start |
| ext_trig | input | 1 | External pin start |
| conv_start | output | 1 | Conversion request pulse |
| conv_chan | output | 4 | Channel to convert, valid with conv_start |
| conv_done | input | 1 | Conversion complete pulse |
| conv_data | input | 12 | Conversion result, valid with conv_done |
| rd_addr | input | 4 | Result register read index |
| rd_data | output | 12 | Result register contents, one cycle after rd_addr |
| busy1 | output | 1 | Sequencer 1 is converting |
| busy2 | output | 1 | Sequencer 2 is converting |
| eos1 | output | 1 | End of sequence pulse, sequencer 1 |
| eos2 | output | 1 | End of sequence pulse, sequencer 2 |

## Verification
The assertions rely on the converter answering each request with exactly one conv_done pulse, never in the same cycle as the conv_start it answers. They also rely on cascade, the run lengths and the slot map staying fixed while either sequencer is busy. The bench converter model waits three cycles before it answers, never answers without an open request, and changes the configuration only after both sequencers have gone idle and their expected runs are used up. Start pulses last one cycle and are driven between clock edges, including a pulse inside a running sequence and one pulse that hits both sequencers at once.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
  typedef enum logic {SQ_IDLE, SQ_CONV} sq_state_t;
  localparam int TRG_SW   = 0;
  localparam int TRG_PWMA = 1;
  localparam int TRG_PWMB = 2;
  localparam int TRG_EXT  = 3;
  localparam int TRG_N    = 4;
  localparam int SEQ_N    = 2;
endpackage

// File: rtl/adcseq_trig_latch.sv
module adcseq_trig_latch
  import adcseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [TRG_N-1:0] mask,
  input  logic [TRG_N-1:0] src,
  input  logic             clr,
  output logic             pend
);
  logic hit;
  assign hit = |(mask & src);

  always_ff @(posedge clk) begin
    if (rst || !enable) pend <= 1'b0;
    else if (hit)       pend <= 1'b1;
    else if (clr)       pend <= 1'b0;
  end
endmodule

// File: rtl/adcseq_result_ram.sv
module adcseq_result_ram #(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/adcseq_core.sv
module adcseq_core
  import adcseq_pkg::*;
#(
  parameter int SLOTS  = 16,
  parameter int CH_W   = 4,
  parameter int DATA_W = 12,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int HALF_W = SLOT_W - 1,
  localparam int HALF   = SLOTS / 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cascade,
  input  logic [SLOTS*CH_W-1:0] slot_chan,
  input  logic [SLOT_W-1:0]     max1,
  input  logic [HALF_W-1:0]     max2,
  input  logic [SEQ_N-1:0]      pend,
  output logic [SEQ_N-1:0]      grant,
  output logic [SEQ_N-1:0]      busy,
  output logic [SEQ_N-1:0]      eos,
  output logic                  conv_start,
  output logic [CH_W-1:0]       conv_chan,
  input  logic                  conv_done,
  input  logic [DATA_W-1:0]     conv_data,
  output logic                  we,
  output logic [SLOT_W-1:0]     waddr,
  output logic [DATA_W-1:0]     wdata
);
  localparam logic [SLOT_W-1:0] HALF_IDX = SLOT_W'(HALF);

  sq_state_t         st;
  logic              own;
  logic [SLOT_W-1:0] slot;
  logic [SLOT_W-1:0] last;
  logic [SLOT_W-1:0] last1, last2, nxt;
  logic [CH_W-1:0]   chan_tab [SLOTS];

  for (genvar s = 0; s < SLOTS; s++) begin : g_tab
    assign chan_tab[s] = slot_chan[s*CH_W +: CH_W];
  end

  assign last1 = cascade ? max1 : {1'b0, max1[HALF_W-1:0]};
  assign last2 = HALF_IDX + SLOT_W'(max2);
  assign nxt   = slot + 1'b1;

  assign grant[0] = (st == SQ_IDLE) && pend[0];
  assign grant[1] = (st == SQ_IDLE) && !pend[0] && pend[1];

  for (genvar k = 0; k < SEQ_N; k++) begin : g_busy
    assign busy[k] = (st == SQ_CONV) && (own == k[0]);
  end

  assign we    = (st == SQ_CONV) && conv_done;
  assign waddr = slot;
  assign wdata = conv_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= SQ_IDLE;
      own        <= 1'b0;
      slot       <= '0;
      last       <= '0;
      conv_start <= 1'b0;
      conv_chan  <= '0;
      eos        <= '0;
    end else begin
      conv_start <= 1'b0;
      eos        <= '0;
      case (st)
        SQ_IDLE: begin
          if (grant[0]) begin
            own        <= 1'b0;
            slot       <= '0;
            last       <= last1;
            conv_start <= 1'b1;
            conv_chan  <= chan_tab[0];
            st         <= SQ_CONV;
          end else if (grant[1]) begin
            own        <= 1'b1;
            slot       <= HALF_IDX;
            last       <= last2;
            conv_start <= 1'b1;
            conv_chan  <= chan_tab[HALF];
            st         <= SQ_CONV;
          end
        end
        SQ_CONV: begin
          if (conv_done) begin
            if (slot == last) begin
              eos[own] <= 1'b1;
              st       <= SQ_IDLE;
            end else begin
              slot       <= nxt;
              conv_start <= 1'b1;
              conv_chan  <= chan_tab[nxt];
            end
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_autoseq.sv
module adc_autoseq
  import adcseq_pkg::*;
#(
  parameter int SLOTS  = 16,
  parameter int CH_W   = 4,
  parameter int DATA_W = 12,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int HALF_W = SLOT_W - 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cascade,
  input  logic [SLOTS*CH_W-1:0] slot_chan,
  input  logic [SLOT_W-1:0]     max_conv1,
  input  logic [HALF_W-1:0]     max_conv2,
  input  logic [TRG_N-1:0]      trig_mask1,
  input  logic [TRG_N-1:0]      trig_mask2,
  input  logic                  sw_start1,
  input  logic                  sw_start2,
  input  logic                  pwm_trig_a,
  input  logic                  pwm_trig_b,
  input  logic                  ext_trig,
  output logic                  conv_start,
  output logic [CH_W-1:0]       conv_chan,
  input  logic                  conv_done,
  input  logic [DATA_W-1:0]     conv_data,
  input  logic [SLOT_W-1:0]     rd_addr,
  output logic [DATA_W-1:0]     rd_data,
  output logic                  busy1,
  output logic                  busy2,
  output logic                  eos1,
  output logic                  eos2
);
  logic [SEQ_N-1:0]  pend, grant, busy, eos;
  logic [TRG_N-1:0]  src   [SEQ_N];
  logic [TRG_N-1:0]  masks [SEQ_N];
  logic              we;
  logic [SLOT_W-1:0] waddr;
  logic [DATA_W-1:0] wdata;

  assign masks[0] = trig_mask1;
  assign masks[1] = trig_mask2;
  assign src[0]   = {ext_trig, pwm_trig_b, pwm_trig_a, sw_start1};
  assign src[1]   = {ext_trig, pwm_trig_b, pwm_trig_a, sw_start2};

  for (genvar k = 0; k < SEQ_N; k++) begin : g_trig
    adcseq_trig_latch u_latch (
      .clk    (clk),
      .rst    (rst),
      .enable ((k == 0) ? 1'b1 : !cascade),
      .mask   (masks[k]),
      .src    (src[k]),
      .clr    (grant[k]),
      .pend   (pend[k])
    );
  end

  adcseq_core #(.SLOTS(SLOTS), .CH_W(CH_W), .DATA_W(DATA_W)) u_core (
    .clk        (clk),
    .rst        (rst),
    .cascade    (cascade),
    .slot_chan  (slot_chan),
    .max1       (max_conv1),
    .max2       (max_conv2),
    .pend       (pend),
    .grant      (grant),
    .busy       (busy),
    .eos        (eos),
    .conv_start (conv_start),
    .conv_chan  (conv_chan),
    .conv_done  (conv_done),
    .conv_data  (conv_data),
    .we         (we),
    .waddr      (waddr),
    .wdata      (wdata)
  );

  adcseq_result_ram #(.DATA_W(DATA_W), .DEPTH(SLOTS)) u_ram (
    .clk   (clk),
    .we    (we),
    .waddr (waddr),
    .wdata (wdata),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  assign busy1 = busy[0];
  assign busy2 = busy[1];
  assign eos1  = eos[0];
  assign eos2  = eos[1];
endmodule

// File: rtl/adc_autoseq_chk.sv
module adc_autoseq_chk (
  input logic clk,
  input logic rst,
  input logic cascade,
  input logic conv_start,
  input logic busy1,
  input logic busy2,
  input logic eos1,
  input logic eos2
);
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start); // R5
  AST_START_IN_RUN: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> (busy1 || busy2)); // R5
  AST_ONE_BUSY: assert property (@(posedge clk) disable iff (rst)
    $onehot0({busy1, busy2})); // R10
  AST_EOS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(eos1 && eos2)); // R10
  AST_CASC_QUIET: assert property (@(posedge clk) disable iff (rst)
    cascade |-> (!busy2 && !eos2)); // R4
  AST_EOS1_IDLE: assert property (@(posedge clk) disable iff (rst)
    eos1 |-> !busy1); // R7
  AST_EOS2_IDLE: assert property (@(posedge clk) disable iff (rst)
    eos2 |-> !busy2); // R7
  AST_EOS1_AFTER_RUN: assert property (@(posedge clk) disable iff (rst)
    eos1 |-> $past(busy1)); // R7
endmodule

bind adc_autoseq adc_autoseq_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .cascade    (cascade),
  .conv_start (conv_start),
  .busy1      (busy1),
  .busy2      (busy2),
  .eos1       (eos1),
  .eos2       (eos2)
);

// File: tb/adc_autoseq_test.sv
module adc_autoseq_test;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cascade = 1'b0;
  logic [63:0] slot_chan;
  logic [3:0]  max_conv1 = '0;
  logic [2:0]  max_conv2 = '0;
  logic [3:0]  trig_mask1 = '0, trig_mask2 = '0;
  logic        sw_start1 = 0, sw_start2 = 0, pwm_trig_a = 0, pwm_trig_b = 0, ext_trig = 0;
  logic        conv_start;
  logic [3:0]  conv_chan;
  logic        conv_done = 1'b0;
  logic [11:0] conv_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [11:0] rd_data;
  logic        busy1, busy2, eos1, eos2;

  always #4 clk = ~clk;

  adc_autoseq uut (
    .clk(clk), .rst(rst), .cascade(cascade), .slot_chan(slot_chan),
    .max_conv1(max_conv1), .max_conv2(max_conv2),
    .trig_mask1(trig_mask1), .trig_mask2(trig_mask2),
    .sw_start1(sw_start1), .sw_start2(sw_start2),
    .pwm_trig_a(pwm_trig_a), .pwm_trig_b(pwm_trig_b), .ext_trig(ext_trig),
    .conv_start(conv_start), .conv_chan(conv_chan),
    .conv_done(conv_done), .conv_data(conv_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .busy1(busy1), .busy2(busy2), .eos1(eos1), .eos2(eos2)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit done_flag = 0;

  // expected request: seq*1024 + last*512 + slot*16 + chan
  int q[$];
  int exp_res [16];
  bit written [16];
  int chan_map [16];
  int eos_pend = 0;   // 0 none, 1 seq1, 2 seq2
  int cd = 0;
  int cur_ent = 0;
  int cnt = 0;

  task automatic check(input string req, input bit ok, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  task automatic push_run(input int seq, input int first, input int last);
    for (int s = first; s <= last; s++)
      q.push_back(seq*1024 + ((s == last) ? 512 : 0) + s*16 + chan_map[s]);
  endtask

  // converter model and per-clock comparison
  initial begin
    forever begin
      @(negedge clk);
      cycles++;
      if (cycles > 150000) begin
        check("watchdog", 0, cycles, 150000);
        finish_run();
      end
      conv_done = 1'b0;
      if (!rst) begin
        if (eos1 || eos2) begin
          check("R7 eos expected", eos_pend != 0, {30'd0, eos2, eos1}, eos_pend);
          check("R7 eos owner", (eos_pend == 1 && eos1) || (eos_pend == 2 && eos2),
                {30'd0, eos2, eos1}, eos_pend);
          check("R7 busy low at eos", !(eos1 && busy1) && !(eos2 && busy2),
                {30'd0, busy2, busy1}, 0);
          check("R10 eos exclusive", !(eos1 && eos2), {30'd0, eos2, eos1}, 1);
          eos_pend = 0;
        end
        check("R10 one busy", !(busy1 && busy2), {30'd0, busy2, busy1}, 1);
        if (cd == 1) begin
          int sl;
          sl = (cur_ent / 16) % 16;
          conv_done = 1'b1;
          conv_data = 12'((cur_ent % 16) * 256 + (cnt % 256));
          cnt++;
          exp_res[sl] = int'(conv_data);
          written[sl] = 1;
          if ((cur_ent / 512) % 2 == 1) eos_pend = cur_ent / 1024 + 1;
        end
        if (cd > 0) cd--;
        if (conv_start) begin
          check("R5 no overlapping request", cd == 0, cd, 0);
          if (q.size() == 0) begin
            check("R2 R4 unexpected request", 0, int'(conv_chan), -1);
          end else begin
            cur_ent = q.pop_front();
            check("R3 channel order", int'(conv_chan) == cur_ent % 16, int'(conv_chan), cur_ent % 16);
            if (cur_ent / 1024 == 0)
              check("R9 owner seq1 busy", busy1 && !busy2, {30'd0, busy2, busy1}, 1);
            else
              check("R9 owner seq2 busy", busy2 && !busy1, {30'd0, busy2, busy1}, 2);
          end
          cd = LAT;
        end
      end
    end
  end

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: sw_start1 = 1;  1: sw_start2 = 1;  2: pwm_trig_a = 1;
      3: pwm_trig_b = 1; default: ext_trig = 1;
    endcase
    @(negedge clk);
    {sw_start1, sw_start2, pwm_trig_a, pwm_trig_b, ext_trig} = '0;
  endtask

  task automatic wait_idle(input string req);
    int k;
    k = 0;
    repeat (2) @(negedge clk);
    while (!(q.size() == 0 && eos_pend == 0 && cd == 0 && !busy1 && !busy2) && k < 3000) begin
      @(negedge clk);
      k++;
    end
    check({req, " run completes"}, k < 3000, q.size(), 0);
  endtask

  task automatic check_results(input string req);
    for (int s = 0; s < 16; s++) begin
      if (written[s]) begin
        @(negedge clk);
        rd_addr = 4'(s);
        @(negedge clk);
        check(req, int'(rd_data) == exp_res[s], int'(rd_data), exp_res[s]);
      end
    end
  endtask

  initial begin
    for (int s = 0; s < 16; s++) begin
      chan_map[s] = (s * 5 + 3) % 16;
      slot_chan[s*4 +: 4] = 4'(chan_map[s]);
      written[s] = 0;
      exp_res[s] = 0;
    end
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 conv_start low", conv_start == 0, int'(conv_start), 0);
    check("R1 busy low", !busy1 && !busy2, {30'd0, busy2, busy1}, 0);
    check("R1 eos low", !eos1 && !eos2, {30'd0, eos2, eos1}, 0);
    repeat (5) @(negedge clk);
    check("R1 idle without start", !busy1 && !busy2, {30'd0, busy2, busy1}, 0);

    // R3 dual: seq1 software start, slots 0..3 (upper bit of max ignored)
    trig_mask1 = 4'b0001; trig_mask2 = 4'b0010;
    max_conv1 = 4'b1011; max_conv2 = 3'd7;
    push_run(0, 0, 3);
    pulse(0);
    wait_idle("R3 seq1");
    check_results("R6 seq1 results");

    // R3 dual: seq2 on PWM event A, slots 8..15
    push_run(1, 8, 15);
    pulse(2);
    wait_idle("R3 seq2");
    check_results("R6 seq2 results");

    // R2 source not enabled: seq1 only software, pulse ext
    pulse(4);
    repeat (20) @(negedge clk);
    check("R2 masked source ignored", !busy1 && !busy2, {30'd0, busy2, busy1}, 0);

    // R9 both on PWM event B, seq1 first
    trig_mask1 = 4'b0100; trig_mask2 = 4'b0100;
    max_conv1 = 4'd1; max_conv2 = 3'd2;
    push_run(0, 0, 1);
    push_run(1, 8, 10);
    pulse(3);
    wait_idle("R9 both");
    check_results("R6 after priority run");

    // R8 retrigger while busy
    trig_mask1 = 4'b0001; trig_mask2 = 4'b0000;
    max_conv1 = 4'd7;
    push_run(0, 0, 7);
    pulse(0);
    repeat (6) @(negedge clk);
    check("R8 seq1 busy during retrigger", busy1, int'(busy1), 1);
    push_run(0, 0, 7);
    pulse(0);
    wait_idle("R8 latched");
    check_results("R6 after latched run");

    // R3 single-slot run
    max_conv1 = 4'd0;
    push_run(0, 0, 0);
    pulse(0);
    wait_idle("R3 single slot");

    // R4 cascaded 16-slot run on external pin; seq2 start ignored
    cascade = 1; max_conv1 = 4'd15;
    trig_mask1 = 4'b1000; trig_mask2 = 4'b0001;
    push_run(0, 0, 15);
    pulse(4);
    pulse(1);
    wait_idle("R4 cascade");
    pulse(1);
    repeat (20) @(negedge clk);
    check("R4 seq2 start ignored", !busy1 && !busy2 && !eos2, {29'd0, eos2, busy2, busy1}, 0);
    check_results("R6 cascade results");

    finish_run();
  end
endmodule